// File: doc/BRIEF.md
# Serial Audio Port Clock Direction Controller

This block decides, for the two timing clocks of a serial audio port, which direction each one runs. The two timing clocks are the bit clock and the frame (left/right) clock. Each clock has its own direction bit, so the port can run in four ways. With both clocks driven it is the timing master. With both clocks received it is a slave. The two mixed combinations are also allowed. A driven bit clock is made by dividing the system clock. A driven frame clock is always counted from whichever bit clock is in effect, whether that bit clock is generated here or received from outside.

The bit clock pin can be handed to another function through a pin-function select. When that happens and the bit clock direction is input, the master clock input becomes the effective bit clock. All received clocks are sampled into the system clock domain. The rest of the port uses the effective bit clock and frame clock that this block presents on its internal outputs.

Top module: `audio_clkdir_ctrl`

## Requirements
- R1: While reset is asserted, both pad output enables and both internal clocks are 0. Both direction settings come out of reset as input (0).
- R2: One clock after the inputs are sampled, `bclk_pad_oe` equals `bclk_dir_i` (1 = output) AND (`pin_func_i` == 1, the bit clock function), and `frm_pad_oe` equals `frm_dir_i` (1 = output). Any other `pin_func_i` value keeps the bit clock pad undriven.
- R3: With the bit clock as output and a divide value d of 2 or more, `bclk_pad_o` has a period of d system clocks and is high for d - floor(d/2) of them. For even d this is a 50% duty cycle.
- R4: With the bit clock as output and a divide value of 0 or 1, `bclk_pad_o` is the system clock itself: high in the high phase of `clk_sys` and low in its low phase. The frame clock then counts one bit period per system clock.
- R5: With the frame clock as output and frame rate r, the frame clock has a period of max(r,2) bit clock periods. It is high for the first floor(max(r,2)/2) of them and low for the rest.
- R6: With the bit clock as input and the pin in bit clock function, the effective bit clock follows `bclk_pad_i`, and a driven frame clock is counted from that external clock.
- R7: With the bit clock as input and the pin in any other function, the effective bit clock follows `mclk_i`, and `bclk_pad_i` has no effect.
- R8: With the bit clock as input, the divide field is ignored. `bclk_int_o` shows the level of the selected external clock two system clocks later.
- R9: With the frame clock as input, the frame rate field is ignored. `frm_int_o` shows the level of `frm_pad_i` two system clocks later.
- R10: A new divide or frame rate value takes effect only at the end of the current bit or frame period. No high or low run shorter than the shorter one of the old and new settings reaches an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; source of the generated bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, fallback bit clock |
| bclk_pad_i | input | 1 | Bit clock pad input |
| frm_pad_i | input | 1 | Frame clock pad input |
| pin_func_i | input | FUNC_W | Bit clock pad function select, 1 = bit clock |
| bclk_dir_i | input | 1 | Bit clock direction, 1 = output |
| frm_dir_i | input | 1 | Frame clock direction, 1 = output |
| bclk_div_i | input | DIV_W | System clocks per bit clock period |
| frm_rate_i | input | RATE_W | Bit clocks per frame |
| bclk_pad_o | output | 1 | Generated bit clock for the pad |
| bclk_pad_oe | output | 1 | Bit clock pad output enable |
| frm_pad_o | output | 1 | Generated frame clock for the pad |
| frm_pad_oe | output | 1 | Frame clock pad output enable |
| bclk_int_o | output | 1 | Effective bit clock for the port |
| frm_int_o | output | 1 | Effective frame clock for the port |

## Verification
A wrong divider count shows at the bit clock pad within a single bit period, as a period or high time that is off from the divide value. A wrong frame count or a wrong latched rate shows within one frame, as a frame period that is not a whole multiple of the bit clock period. A bad source select or a broken synchroniser stage shows two system clocks after an external level change, when the internal clocks fail to follow that change. A missed boundary latch shows as a short run in the cycles right after a divide or rate change.

// File: rtl/acd_pkg.sv
package acd_pkg;
  // Which clock is acting as the effective bit clock
  typedef enum logic [1:0] {
    SRC_DIV  = 2'd0,
    SRC_PAD  = 2'd1,
    SRC_MCLK = 2'd2
  } bclk_src_e;
endpackage

// File: rtl/acd_sync.sv
module acd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/acd_bclk_div.sv
module acd_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_o,
  output logic             bypass_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  function automatic logic [DIV_W-1:0] last_of(input logic [DIV_W-1:0] d);
    return (d < TWO) ? '0 : d - ONE;
  endfunction

  function automatic logic [DIV_W-1:0] high_of(input logic [DIV_W-1:0] d);
    return (d < TWO) ? ONE : d - (d >> 1);
  endfunction

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!en_i) begin
      // Park at the last count so the first enabled cycle starts a full high phase
      div_d = div_i;
      cnt_d = last_of(div_i);
      lvl_d = 1'b0;
    end else if (cnt_q == last_of(div_q)) begin
      div_d = div_i;
      cnt_d = '0;
      lvl_d = 1'b1;
    end else begin
      cnt_d = cnt_q + ONE;
      lvl_d = (cnt_d < high_of(div_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign bypass_o = (div_q < TWO);
  assign lvl_o    = lvl_q;
  assign fall_o   = en_i & (bypass_o | (lvl_q & ~lvl_d));

  AST_BCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lvl_o); // R3
  AST_BCLK_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o && !bypass_o) |=> !lvl_o); // R3
endmodule

// File: rtl/acd_frame_div.sv
module acd_frame_div #(
  parameter int RATE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              lvl_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);
  localparam logic [RATE_W-1:0] TWO = RATE_W'(2);

  function automatic logic [RATE_W-1:0] clamp(input logic [RATE_W-1:0] r);
    return (r < TWO) ? TWO : r;
  endfunction

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    rate_d = rate_q;
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    if (!en_i || restart_i) begin
      rate_d = clamp(rate_i);
      cnt_d  = rate_d - ONE;
      lvl_d  = 1'b0;
    end else if (tick_i) begin
      if (cnt_q == rate_q - ONE) begin
        rate_d = clamp(rate_i);
        cnt_d  = '0;
        lvl_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
        lvl_d = (cnt_d < (rate_q >> 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= TWO;
      cnt_q  <= ONE;
      lvl_q  <= 1'b0;
    end else begin
      rate_q <= rate_d;
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  AST_FRM_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i && !tick_i) |=> $stable(lvl_o)); // R5
  AST_FRM_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !lvl_o); // R5
endmodule

// File: rtl/audio_clkdir_ctrl.sv
module audio_clkdir_ctrl
  import acd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int RATE_W      = 11,
  parameter int FUNC_W      = 4,
  parameter int FUNC_BCLK   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              mclk_i,
  input  logic              bclk_pad_i,
  input  logic              frm_pad_i,
  input  logic [FUNC_W-1:0] pin_func_i,
  input  logic              bclk_dir_i,
  input  logic              frm_dir_i,
  input  logic [DIV_W-1:0]  bclk_div_i,
  input  logic [RATE_W-1:0] frm_rate_i,
  output logic              bclk_pad_o,
  output logic              bclk_pad_oe,
  output logic              frm_pad_o,
  output logic              frm_pad_oe,
  output logic              bclk_int_o,
  output logic              frm_int_o
);
  localparam logic [FUNC_W-1:0] FUNC_BCLK_V = FUNC_W'(FUNC_BCLK);

  // ---------------- configuration capture ----------------
  logic              bdir_q, fdir_q;
  logic [FUNC_W-1:0] func_q;
  logic [DIV_W-1:0]  div_q;
  logic [RATE_W-1:0] rate_q;
  logic              cfg_en;

  assign cfg_en = 1'b1;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      bdir_q <= 1'b0;
      fdir_q <= 1'b0;
      func_q <= FUNC_BCLK_V;
      div_q  <= '0;
      rate_q <= '0;
    end else if (cfg_en) begin
      bdir_q <= bclk_dir_i;
      fdir_q <= frm_dir_i;
      func_q <= pin_func_i;
      div_q  <= bclk_div_i;
      rate_q <= frm_rate_i;
    end
  end

  logic pin_is_bclk;
  assign pin_is_bclk = (func_q == FUNC_BCLK_V);

  // ---------------- external clock sampling ----------------
  logic [2:0] sync_lvl;

  acd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .async_i ({mclk_i, bclk_pad_i, frm_pad_i}),
    .level_o (sync_lvl)
  );

  logic ext_lvl, ext_prev_q, ext_fall;
  assign ext_lvl  = pin_is_bclk ? sync_lvl[1] : sync_lvl[2];
  assign ext_fall = ext_prev_q & ~ext_lvl;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_lvl;
  end

  // ---------------- bit clock generation ----------------
  logic div_lvl, div_byp, div_fall, bclk_gen;

  acd_bclk_div #(.DIV_W(DIV_W)) u_bdiv (
    .clk      (clk_sys),
    .rst_n    (rst_n),
    .en_i     (bdir_q),
    .div_i    (div_q),
    .lvl_o    (div_lvl),
    .bypass_o (div_byp),
    .fall_o   (div_fall)
  );

  assign bclk_gen = bdir_q & (div_byp ? clk_sys : div_lvl);

  // ---------------- effective bit clock select ----------------
  bclk_src_e src_sel, src_q;
  logic      src_chg, bclk_tick;

  always_comb begin
    if (bdir_q)           src_sel = SRC_DIV;
    else if (pin_is_bclk) src_sel = SRC_PAD;
    else                  src_sel = SRC_MCLK;
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_PAD;
    else        src_q <= src_sel;
  end

  assign src_chg   = (src_sel != src_q);
  assign bclk_tick = (src_sel == SRC_DIV) ? div_fall : ext_fall;

  // ---------------- frame clock generation ----------------
  logic frm_lvl;

  acd_frame_div #(.RATE_W(RATE_W)) u_fdiv (
    .clk       (clk_sys),
    .rst_n     (rst_n),
    .en_i      (fdir_q),
    .restart_i (src_chg),
    .tick_i    (bclk_tick),
    .rate_i    (rate_q),
    .lvl_o     (frm_lvl)
  );

  // ---------------- outputs ----------------
  assign bclk_pad_o  = bclk_gen;
  assign bclk_pad_oe = bdir_q & pin_is_bclk;
  assign frm_pad_o   = frm_lvl;
  assign frm_pad_oe  = fdir_q;
  assign bclk_int_o  = bdir_q ? bclk_gen : ext_lvl;
  assign frm_int_o   = fdir_q ? frm_lvl : sync_lvl[0];

  // ---------------- checks ----------------
  logic [1:0] live_q;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)              live_q <= 2'd0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  AST_BCLK_OE_CFG: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (live_q != 2'd0) |-> bclk_pad_oe == $past(bclk_dir_i && (pin_func_i == FUNC_BCLK_V))); // R2
  AST_FRM_OE_CFG: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (live_q != 2'd0) |-> frm_pad_oe == $past(frm_dir_i)); // R2

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_FRM_SLAVE_FOLLOW: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (live_q >= 2'd2 && !frm_pad_oe) |-> frm_int_o == $past(frm_pad_i, 2)); // R9
    end
  endgenerate
endmodule

// File: tb/test_audio_clkdir_ctrl.sv
`timescale 1ns/1ps
module test_audio_clkdir_ctrl;
  localparam int DIV_W  = 8;
  localparam int RATE_W = 11;
  localparam int FUNC_W = 4;
  localparam int LIM    = 3000;

  logic              clk_sys = 1'b0;
  logic              rst_n;
  logic              mclk_i, bclk_pad_i, frm_pad_i;
  logic [FUNC_W-1:0] pin_func_i;
  logic              bclk_dir_i, frm_dir_i;
  logic [DIV_W-1:0]  bclk_div_i;
  logic [RATE_W-1:0] frm_rate_i;
  logic bclk_pad_o, bclk_pad_oe, frm_pad_o, frm_pad_oe, bclk_int_o, frm_int_o;

  int checks = 0;
  int errors = 0;
  int ext_half = 0, mclk_half = 0;
  logic bclk_static = 1'b0;
  int ext_cnt = 0, mclk_cnt = 0;

  always #10 clk_sys = ~clk_sys;

  audio_clkdir_ctrl i_audio_clkdir_ctrl (
    .clk_sys(clk_sys), .rst_n(rst_n), .mclk_i(mclk_i), .bclk_pad_i(bclk_pad_i),
    .frm_pad_i(frm_pad_i), .pin_func_i(pin_func_i), .bclk_dir_i(bclk_dir_i),
    .frm_dir_i(frm_dir_i), .bclk_div_i(bclk_div_i), .frm_rate_i(frm_rate_i),
    .bclk_pad_o(bclk_pad_o), .bclk_pad_oe(bclk_pad_oe), .frm_pad_o(frm_pad_o),
    .frm_pad_oe(frm_pad_oe), .bclk_int_o(bclk_int_o), .frm_int_o(frm_int_o)
  );

  // external clock sources
  always @(negedge clk_sys) begin
    if (ext_half > 0) begin
      ext_cnt++;
      if (ext_cnt >= ext_half) begin bclk_pad_i <= ~bclk_pad_i; ext_cnt = 0; end
    end else bclk_pad_i <= bclk_static;
    if (mclk_half > 0) begin
      mclk_cnt++;
      if (mclk_cnt >= mclk_half) begin mclk_i <= ~mclk_i; mclk_cnt = 0; end
    end else mclk_i <= 1'b0;
  end

  function automatic int eff_d(input int d); return (d < 2) ? 1 : d; endfunction
  function automatic int bhi(input int d); return d - d / 2; endfunction
  function automatic int fr(input int r); return (r < 2) ? 2 : r; endfunction

  function automatic logic sig(input int which);
    case (which)
      0: return bclk_pad_o;
      1: return frm_pad_o;
      2: return bclk_int_o;
      default: return frm_int_o;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic meas(input int which, output int hi, output int per);
    int n, lo;
    hi = -1; per = -1;
    n = 0; while (sig(which) !== 1'b0 && n < LIM) begin @(negedge clk_sys); n++; end
    n = 0; while (sig(which) !== 1'b1 && n < LIM) begin @(negedge clk_sys); n++; end
    if (n >= LIM) return;
    hi = 0; while (sig(which) === 1'b1 && hi < LIM) begin @(negedge clk_sys); hi++; end
    lo = 0; while (sig(which) === 1'b0 && lo < LIM) begin @(negedge clk_sys); lo++; end
    per = hi + lo;
  endtask

  task automatic meas2(input int which, output int hi, output int per);
    meas(which, hi, per);
    meas(which, hi, per);
  endtask

  task automatic run_bounds(input int which, input int n, output int mn, output int mx);
    logic prev, cur;
    int run;
    bit first;
    first = 1'b1; mn = 1000000; mx = 0; run = 1; prev = sig(which);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_sys);
      cur = sig(which);
      if (cur === prev) run++;
      else begin
        if (!first) begin
          if (run < mn) mn = run;
          if (run > mx) mx = run;
        end
        first = 1'b0; run = 1; prev = cur;
      end
    end
  endtask

  task automatic cfg(input logic bd, input logic fd, input int func, input int d, input int r);
    @(negedge clk_sys);
    bclk_dir_i = bd; frm_dir_i = fd;
    pin_func_i = FUNC_W'(func); bclk_div_i = DIV_W'(d); frm_rate_i = RATE_W'(r);
  endtask

  initial begin
    repeat (150000) @(posedge clk_sys);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, mn, mx, d, r;
    logic v1, v0;
    void'($urandom(32'd2718));
    rst_n = 1'b0; frm_pad_i = 1'b1;
    bclk_dir_i = 1'b1; frm_dir_i = 1'b1; pin_func_i = 4'd1;
    bclk_div_i = 8'd4; frm_rate_i = 11'd4;
    repeat (3) @(negedge clk_sys);
    // R1: reset forces everything low
    check("R1 bclk_pad_oe", int'(bclk_pad_oe), 0);
    check("R1 frm_pad_oe", int'(frm_pad_oe), 0);
    check("R1 bclk_int_o", int'(bclk_int_o), 0);
    check("R1 frm_int_o", int'(frm_int_o), 0);
    bclk_dir_i = 1'b0; frm_dir_i = 1'b0; frm_pad_i = 1'b0;
    @(negedge clk_sys); rst_n = 1'b1;
    repeat (2) @(negedge clk_sys);
    check("R1 oe after reset", int'(bclk_pad_oe) + int'(frm_pad_oe), 0);

    // R2: output enables
    cfg(1'b1, 1'b0, 3, 4, 4); repeat (2) @(negedge clk_sys);
    check("R2 bclk oe other func", int'(bclk_pad_oe), 0);
    cfg(1'b1, 1'b1, 1, 4, 4); repeat (2) @(negedge clk_sys);
    check("R2 bclk oe", int'(bclk_pad_oe), 1);
    check("R2 frm oe", int'(frm_pad_oe), 1);
    cfg(1'b0, 1'b0, 1, 4, 4); repeat (2) @(negedge clk_sys);
    check("R2 both off", int'(bclk_pad_oe) + int'(frm_pad_oe), 0);

    // R3 / R5: directed master cases incl. clamped rate
    cfg(1'b1, 1'b1, 1, 2, 0);
    meas2(0, hi, per); check("R3 d2 period", per, 2); check("R3 d2 high", hi, 1);
    meas2(1, hi, per); check("R5 clamp period", per, 4); check("R5 clamp high", hi, 2);
    cfg(1'b1, 1'b1, 1, 5, 7);
    meas2(0, hi, per); check("R3 d5 period", per, 5); check("R3 d5 high", hi, 3);
    meas2(1, hi, per); check("R5 r7 period", per, 35); check("R5 r7 high", hi, 15);

    // R3 / R5: random master configurations
    for (int k = 0; k < 16; k++) begin
      d = $urandom_range(2, 10); r = $urandom_range(0, 14);
      cfg(1'b1, 1'b1, 1, d, r);
      meas2(0, hi, per);
      check("R3 rand period", per, d); check("R3 rand high", hi, bhi(d));
      meas2(1, hi, per);
      check("R5 rand period", per, eff_d(d) * fr(r));
      check("R5 rand high", hi, eff_d(d) * (fr(r) / 2));
    end

    // R4: pass-through for divide 1 and 0
    for (int k = 0; k < 2; k++) begin
      cfg(1'b1, 1'b1, 1, k, 6); repeat (4) @(negedge clk_sys);
      @(posedge clk_sys); #5 v1 = bclk_pad_o;
      @(negedge clk_sys); #5 v0 = bclk_pad_o;
      check("R4 high phase", int'(v1), 1); check("R4 low phase", int'(v0), 0);
      @(negedge clk_sys);
      meas2(1, hi, per); check("R4 frame period", per, 6); check("R4 frame high", hi, 3);
    end

    // R6: frame counted from external bit clock
    ext_half = 3;
    cfg(1'b0, 1'b1, 1, 9, 5);
    meas2(2, hi, per); check("R6 bclk_int period", per, 6); check("R6 bclk_int high", hi, 3);
    meas2(1, hi, per); check("R6 frame period", per, 30); check("R6 frame high", hi, 12);
    ext_half = 0;

    // R7: master clock as bit clock, pad ignored
    bclk_static = 1'b1; mclk_half = 2;
    cfg(1'b0, 1'b1, 3, 7, 6);
    meas2(2, hi, per); check("R7 bclk_int period", per, 4); check("R7 bclk_int high", hi, 2);
    meas2(1, hi, per); check("R7 frame period", per, 24); check("R7 frame high", hi, 12);
    check("R7 bclk oe", int'(bclk_pad_oe), 0);
    mclk_half = 0;

    // R8: bit clock input follows pad, divide ignored
    bclk_static = 1'b1;
    cfg(1'b0, 1'b0, 1, 3, 4); repeat (4) @(negedge clk_sys);
    check("R8 follow high", int'(bclk_int_o), 1);
    cfg(1'b0, 1'b0, 1, 11, 4); repeat (4) @(negedge clk_sys);
    check("R8 div ignored", int'(bclk_int_o), 1);
    bclk_static = 1'b0; repeat (4) @(negedge clk_sys);
    check("R8 follow low", int'(bclk_int_o), 0);
    check("R8 oe", int'(bclk_pad_oe), 0);

    // R9: frame input follows pad, rate ignored
    cfg(1'b0, 1'b0, 1, 3, 9); frm_pad_i = 1'b1; repeat (4) @(negedge clk_sys);
    check("R9 follow high", int'(frm_int_o), 1);
    cfg(1'b0, 1'b0, 1, 3, 2); repeat (4) @(negedge clk_sys);
    check("R9 rate ignored", int'(frm_int_o), 1);
    frm_pad_i = 1'b0; repeat (4) @(negedge clk_sys);
    check("R9 follow low", int'(frm_int_o), 0);
    check("R9 oe", int'(frm_pad_oe), 0);

    // R10: boundary-aligned divide change
    cfg(1'b1, 1'b0, 1, 4, 4); repeat (10) @(negedge clk_sys);
    fork
      run_bounds(0, 80, mn, mx);
      begin repeat (37) @(negedge clk_sys); bclk_div_i = 8'd6; end
    join
    check("R10 bclk min run", int'(mn >= 2), 1); check("R10 bclk max run", int'(mx <= 3), 1);

    // R10: boundary-aligned rate change
    cfg(1'b1, 1'b1, 1, 2, 4); repeat (20) @(negedge clk_sys);
    fork
      run_bounds(1, 200, mn, mx);
      begin repeat (53) @(negedge clk_sys); frm_rate_i = 11'd8; end
    join
    check("R10 frame min run", int'(mn >= 4), 1); check("R10 frame max run", int'(mx <= 8), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule